// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock of an I2C bus master from the peripheral clock. It drives the clock line through an open-drain enable, senses the real level of the line, and gives the bit engine one-cycle strobes at the start of each low phase and each high phase. The high and low phase lengths come from a 12-bit divider value in a control word. Standard mode uses a 1:1 high-to-low ratio. Fast mode uses 1:2, or 9:16 when the duty bit is set.

After the line is released, a rise-time window absorbs slow edges. A slave holding the line low freezes the high-phase count, so clock stretching lengthens the period and no high time is lost. The generator runs only while the peripheral is enabled, a transfer is active and the stated clock frequency suits the selected mode. At all other times the line is released.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, `scl_oe_o`, `scl_fall_tick_o` and `scl_rise_tick_o` are all 0.
- R2: In standard mode (`clk_ctl_i[15]`=0), with C the divider in `clk_ctl_i[11:0]` after clamping, each low phase drives `scl_oe_o`=1 for exactly C cycles. With fast edges and no stretching, the released time is C plus the release window of R7.
- R3: In fast mode (`clk_ctl_i[15]`=1) with `clk_ctl_i[14]`=0, the low phase lasts 2·C cycles and the high count is C.
- R4: In fast mode with `clk_ctl_i[14]`=1, the low phase lasts 16·C cycles and the high count is 9·C.
- R5: A divider below the mode minimum is raised to that minimum: 4 in standard mode and 1 in fast mode.
- R6: `freq_mhz_i` must lie in 2..46 for standard mode and in 6..46 for fast mode. Outside that range the line stays released and no strobe is produced.
- R7: Let W = max(`rise_cnt_i`,1) and let S be the first cycle after release in which the line is sensed high, counting the two synchronizer stages. If S < W, the high count starts in cycle S+1, and the released time is S+1+H, where H is the high count. Otherwise the high count starts in cycle W, counts only sensed-high cycles, and the released time is S+H.
- R8: While the line is sensed low during the high phase, the high count holds. `scl_oe_o` stays 0 until the count completes after the line returns high.
- R9: `scl_fall_tick_o` is 1 for exactly the first cycle of each low phase. `scl_rise_tick_o` is 1 for exactly the first cycle of the high phase, which is cycle S+1 or W of R7.
- R10: When `enable_i` or `xfer_active_i` goes low, the line is released and the strobes stop from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Peripheral enabled |
| xfer_active_i | input | 1 | Master transfer in progress |
| clk_ctl_i | input | 16 | [11:0] divider, [14] duty select, [15] fast mode |
| rise_cnt_i | input | 6 | Maximum rise time in clock periods, plus one |
| freq_mhz_i | input | 6 | Peripheral clock frequency in MHz |
| scl_i | input | 1 | Sensed level of the clock line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| scl_fall_tick_o | output | 1 | Strobe on the first cycle of a low phase |
| scl_rise_tick_o | output | 1 | Strobe on the first cycle of a high phase |

## Verification
The hardest case to reach is a line that stays low past the rise window. That case is the only way to reach the high phase by expiry and then exercise the frozen counter. The bench models the line as the inverse of the drive, gated by a hold flag that stands in for a stretching slave. It lets go of the hold at a chosen cycle of the released time, for release points both inside and beyond the window. The bench then measures the released time and the position of the rise strobe against the arithmetic of R7 and R8.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int CTL_W        = 16;
  localparam int CTL_FAST_BIT = 15;
  localparam int CTL_DUTY_BIT = 14;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_REL  = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
  import scl_gen_pkg::*;
#(
  parameter int CCR_W         = 12,
  parameter int RISE_W        = 6,
  parameter int FREQ_W        = 6,
  parameter int MIN_CCR_STD   = 4,
  parameter int MIN_CCR_FAST  = 1,
  parameter int FREQ_MIN_STD  = 2,
  parameter int FREQ_MIN_FAST = 6,
  parameter int FREQ_MAX      = 46,
  localparam int CNT_W        = CCR_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [RISE_W-1:0] rise_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [CNT_W-1:0]  hi_len_o,
  output logic [CNT_W-1:0]  lo_len_o,
  output logic [RISE_W-1:0] rise_len_o,
  output logic              cfg_ok_o
);
  logic             fast, duty;
  logic [CCR_W-1:0] ccr_raw, ccr_eff;
  logic [CNT_W-1:0] c;
  logic             unused_ctl;

  assign fast       = ctl_i[CTL_FAST_BIT];
  assign duty       = ctl_i[CTL_DUTY_BIT];
  assign ccr_raw    = ctl_i[CCR_W-1:0];
  assign unused_ctl = ^ctl_i[CTL_DUTY_BIT-1:CCR_W];

  always_comb begin
    if (fast) ccr_eff = (ccr_raw < CCR_W'(MIN_CCR_FAST)) ? CCR_W'(MIN_CCR_FAST) : ccr_raw;
    else      ccr_eff = (ccr_raw < CCR_W'(MIN_CCR_STD))  ? CCR_W'(MIN_CCR_STD)  : ccr_raw;
  end

  assign c = CNT_W'(ccr_eff);

  // duty select matters only in fast mode
  always_comb begin
    if (!fast) begin
      hi_len_o = c;
      lo_len_o = c;
    end else if (!duty) begin
      hi_len_o = c;
      lo_len_o = c << 1;
    end else begin
      hi_len_o = (c << 3) + c;
      lo_len_o = c << 4;
    end
  end

  assign rise_len_o = (rise_i == '0) ? RISE_W'(1) : rise_i;

  always_comb begin
    if (fast) cfg_ok_o = (freq_i >= FREQ_W'(FREQ_MIN_FAST)) && (freq_i <= FREQ_W'(FREQ_MAX));
    else      cfg_ok_o = (freq_i >= FREQ_W'(FREQ_MIN_STD))  && (freq_i <= FREQ_W'(FREQ_MAX));
  end

  AST_LOW_LEN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_len_o >= CNT_W'(2)) else $error("low length below 2"); // R5
  AST_HIGH_LEN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_len_o >= CNT_W'(1)) else $error("high length zero"); // R5
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh[0] <= 1'b1;
        else         sh[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh[g] <= 1'b1;
        else         sh[g] <= sh[g-1];
    end
  end

  assign q_o = sh[STAGES-1];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W  = 17,
  parameter int RISE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              scl_s_i,
  input  logic [CNT_W-1:0]  hi_len_i,
  input  logic [CNT_W-1:0]  lo_len_i,
  input  logic [RISE_W-1:0] rise_len_i,
  output logic              scl_oe_o,
  output logic              fall_tick_o,
  output logic              rise_tick_o
);
  phase_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RISE_W-1:0] rcnt_q;
  logic              fall_q, rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      rcnt_q <= '0;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      if (!run_i) begin
        st_q <= PH_IDLE;
      end else begin
        unique case (st_q)
          PH_IDLE: begin
            st_q   <= PH_LOW;
            cnt_q  <= lo_len_i - CNT_W'(1);
            fall_q <= 1'b1;
          end
          PH_LOW: begin
            if (cnt_q == '0) begin
              st_q   <= PH_REL;
              rcnt_q <= rise_len_i - RISE_W'(1);
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          PH_REL: begin
            // leave on a sensed-high line or when the rise window runs out
            if (scl_s_i || rcnt_q == '0) begin
              st_q   <= PH_HIGH;
              cnt_q  <= hi_len_i - CNT_W'(1);
              rise_q <= 1'b1;
            end else begin
              rcnt_q <= rcnt_q - RISE_W'(1);
            end
          end
          PH_HIGH: begin
            // a low line here is a stretching slave: hold the count
            if (scl_s_i) begin
              if (cnt_q == '0) begin
                st_q   <= PH_LOW;
                cnt_q  <= lo_len_i - CNT_W'(1);
                fall_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q - CNT_W'(1);
              end
            end
          end
          default: st_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign scl_oe_o    = (st_q == PH_LOW);
  assign fall_tick_o = fall_q;
  assign rise_tick_o = rise_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!scl_oe_o && !fall_tick_o && !rise_tick_o)) else $error("not released"); // R10
  AST_LOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_LOW && cnt_q != '0 && run_i) |=> scl_oe_o) else $error("low cut short"); // R2
  AST_RISE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_REL && rcnt_q == '0 && run_i) |=> (st_q == PH_HIGH)) else $error("rise window overrun"); // R7
  AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_HIGH && !scl_s_i && run_i) |=> (cnt_q == $past(cnt_q))) else $error("count moved"); // R8
  AST_ROSE_HAS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> fall_tick_o) else $error("missing fall tick"); // R9
  AST_FALL_TICK_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_tick_o |-> scl_oe_o) else $error("fall tick while released"); // R9
  AST_RISE_TICK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_tick_o |-> !scl_oe_o) else $error("rise tick while driven"); // R9
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_gen_pkg::*;
#(
  parameter int CCR_W         = 12,
  parameter int RISE_W        = 6,
  parameter int FREQ_W        = 6,
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_CCR_STD   = 4,
  parameter int MIN_CCR_FAST  = 1,
  parameter int FREQ_MIN_STD  = 2,
  parameter int FREQ_MIN_FAST = 6,
  parameter int FREQ_MAX      = 46
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              xfer_active_i,
  input  logic [CTL_W-1:0]  clk_ctl_i,
  input  logic [RISE_W-1:0] rise_cnt_i,
  input  logic [FREQ_W-1:0] freq_mhz_i,
  input  logic              scl_i,
  output logic              scl_oe_o,
  output logic              scl_fall_tick_o,
  output logic              scl_rise_tick_o
);
  localparam int CNT_W = CCR_W + 5;

  logic [CNT_W-1:0]  hi_len, lo_len;
  logic [RISE_W-1:0] rise_len;
  logic              cfg_ok, run, scl_s;

  scl_cfg_decode #(
    .CCR_W(CCR_W), .RISE_W(RISE_W), .FREQ_W(FREQ_W),
    .MIN_CCR_STD(MIN_CCR_STD), .MIN_CCR_FAST(MIN_CCR_FAST),
    .FREQ_MIN_STD(FREQ_MIN_STD), .FREQ_MIN_FAST(FREQ_MIN_FAST), .FREQ_MAX(FREQ_MAX)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ctl_i(clk_ctl_i), .rise_i(rise_cnt_i), .freq_i(freq_mhz_i),
    .hi_len_o(hi_len), .lo_len_o(lo_len), .rise_len_o(rise_len), .cfg_ok_o(cfg_ok)
  );

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
  );

  assign run = enable_i && xfer_active_i && cfg_ok;

  scl_phase_fsm #(.CNT_W(CNT_W), .RISE_W(RISE_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .scl_s_i(scl_s),
    .hi_len_i(hi_len), .lo_len_i(lo_len), .rise_len_i(rise_len),
    .scl_oe_o(scl_oe_o), .fall_tick_o(scl_fall_tick_o), .rise_tick_o(scl_rise_tick_o)
  );

  AST_BAD_FREQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ok |=> !scl_oe_o) else $error("driven with bad frequency"); // R6
endmodule

// File: tb/scl_clkgen_bench.sv
`timescale 1ns/1ps
module scl_clkgen_bench;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, act = 1'b0, hold = 1'b0;
  logic [15:0] ctl = '0;
  logic [5:0]  rise = '0, freq = 6'd8;
  logic        oe, ft, rt, scl_line;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  assign scl_line = ~oe & ~hold;

  scl_clkgen u_scl_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .xfer_active_i(act),
    .clk_ctl_i(ctl), .rise_cnt_i(rise), .freq_mhz_i(freq), .scl_i(scl_line),
    .scl_oe_o(oe), .scl_fall_tick_o(ft), .scl_rise_tick_o(rt)
  );

  task automatic check(string req, string what, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // fast, duty, divider, rise field, hold release index, requirement tag
  task automatic run_case(bit fast, bit duty, int ccr, int rv, int hc, string req);
    int c, hl, ll, w, s, exp_hi, exp_rt, lo, hi, rti, tries;
    c  = fast ? ((ccr < 1) ? 1 : ccr) : ((ccr < 4) ? 4 : ccr);
    hl = (fast && duty) ? 9 * c : c;
    ll = !fast ? c : (duty ? 16 * c : 2 * c);
    w  = (rv == 0) ? 1 : rv;
    s  = hc + SYNC;
    exp_hi = (s < w) ? s + 1 + hl : s + hl;
    exp_rt = (s < w) ? s + 1 : w;
    @(negedge clk);
    act  = 1'b0;
    ctl  = {fast, duty, 2'b00, 12'(ccr)};
    rise = 6'(rv);
    freq = 6'd8;
    repeat (3) @(negedge clk);
    act = 1'b1;
    tries = 0;
    while (!oe && tries < 100) begin tries++; @(negedge clk); end
    for (int p = 0; p < 2; p++) begin
      check("R9", "fall tick at low start", int'(ft), 1);
      hold = (hc > 0);
      lo = 0;
      while (oe && lo < 70000) begin lo++; @(negedge clk); end
      hi = 0; rti = -1;
      while (!oe && hi < 70000) begin
        if (rt) rti = hi;
        if (hold && hi == hc) hold = 1'b0;
        hi++;
        @(negedge clk);
      end
      check(req, $sformatf("low length ccr=%0d fast=%0d duty=%0d", ccr, fast, duty), lo, ll);
      check((hc > 0) ? "R8" : req, $sformatf("released length ccr=%0d rise=%0d hold=%0d", ccr, rv, hc), hi, exp_hi);
      check((rv != 9 && hc == 0) ? "R7" : "R9", "rise tick position", rti, exp_rt);
    end
    act  = 1'b0;
    hold = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet_case(bit fast, int f, bit expect_run, string req);
    int seen;
    @(negedge clk);
    act  = 1'b0;
    ctl  = {fast, 1'b0, 2'b00, 12'd5};
    rise = 6'd3;
    freq = 6'(f);
    repeat (2) @(negedge clk);
    act  = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (oe || ft || rt) seen = 1;
    end
    check(req, $sformatf("activity with freq=%0d fast=%0d", f, fast), seen, int'(expect_run));
    act = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "oe in reset", int'(oe), 0);
    rst_n = 1'b1;
    en    = 1'b1;
    @(negedge clk);
    check("R1", "oe after reset", int'(oe), 0);
    check("R1", "ticks after reset", int'(ft | rt), 0);

    // standard mode sweep, including clamped dividers (R2, R5)
    for (int k = 0; k <= 6; k++) run_case(1'b0, 1'b0, k, 9, 0, (k < 4) ? "R5" : "R2");
    // fast mode, duty 0 (R3, R5)
    for (int k = 0; k <= 5; k++) run_case(1'b1, 1'b0, k, 3, 0, (k < 1) ? "R5" : "R3");
    // fast mode, duty 1 (R4)
    for (int k = 0; k <= 2; k++) run_case(1'b1, 1'b1, k, 4, 0, (k < 1) ? "R5" : "R4");
    // rise window sweep (R7)
    for (int r = 0; r <= 4; r++) run_case(1'b0, 1'b0, 5, r, 0, "R7");
    // stretching slave, released inside and beyond the window (R8)
    run_case(1'b0, 1'b0, 5, 2, 5, "R8");
    run_case(1'b0, 1'b0, 4, 9, 1, "R8");
    run_case(1'b0, 1'b0, 4, 9, 12, "R8");
    run_case(1'b1, 1'b0, 2, 1, 10, "R8");

    // frequency window (R6)
    quiet_case(1'b0, 1,  1'b0, "R6");
    quiet_case(1'b0, 2,  1'b1, "R6");
    quiet_case(1'b0, 46, 1'b1, "R6");
    quiet_case(1'b0, 47, 1'b0, "R6");
    quiet_case(1'b1, 5,  1'b0, "R6");
    quiet_case(1'b1, 6,  1'b1, "R6");
    quiet_case(1'b1, 46, 1'b1, "R6");

    // stop during a low phase (R10)
    @(negedge clk);
    ctl = {1'b0, 1'b0, 2'b00, 12'd20};
    freq = 6'd8;
    act = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "driven before stop", int'(oe), 1);
    act = 1'b0;
    @(negedge clk);
    check("R10", "released after transfer stop", int'(oe), 0);
    act = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R10", "released after disable", int'(oe), 0);
    repeat (5) @(negedge clk);
    check("R10", "quiet while disabled", int'(oe | ft | rt), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule